// File: doc/BRIEF.md
# Local Wake-Up Pin Detector

This block watches two local wake-up inputs and turns qualifying level changes on them into wake events. Each input has its own two-bit edge setting: it can react to falling edges, rising edges, both, or nothing. Every input is first brought into the clock domain through a two-flop synchronizer. An input can be watched continuously, or only at a periodic sampling instant. In sampled mode, edges are found by comparing one latched sample with the previous one.

A millisecond tick drives a period counter. Whenever at least one input uses sampled mode, the block raises a bias strobe for a short settling window just before each sampling instant. One control bit sets the period to 16 or 64 ticks. Outside Sleep, a detected edge becomes a per-pin wake event pulse. In Sleep, the same edge instead raises a request to move to Standby. The current level of each input (the latched level in sampled mode) is reported on a status output. That output is forced to zero while both inputs are disabled.

Top module: `wake_pin_detect`

## Requirements
- R1: While reset is held and on the first cycle after it, `wake_evt`, `wake_req`, `level_stat` and `bias_out` are all 0. The internal view of each pin starts at level 0.
- R2: Each pin's 2-bit field in `edge_cfg` (pin i uses bits 2i+1:2i) selects the edges that count: 2'b00 none, 2'b01 falling, 2'b10 rising, 2'b11 both.
- R3: Each pin is detected on its own. An edge on one pin never produces an event or request for the other pin.
- R4: `chip_mode` encodes 2'b00 Sleep, 2'b01 Standby, and 2'b10 or 2'b11 Normal. In Standby or Normal, a counted edge on pin i pulses `wake_evt[i]` and leaves `wake_req` at 0.
- R5: In Sleep, a counted edge on any pin pulses `wake_req`, and `wake_evt` stays 0.
- R6: `level_stat` shows each pin's observed level when at least one `edge_cfg` field is non-zero. When all fields are 2'b00, `level_stat` is 0.
- R7: In continuous mode (`samp_en[i]`=0), a pin change driven before a clock edge shows up as a one-cycle event in the cycle after the second clock edge, which is the synchronizer latency.
- R8: In sampled mode (`samp_en[i]`=1), the pin level is latched only at the sampling instant. This instant is the tick that completes a period, counted from when sampling was enabled. Edges are found between successive samples, so a pulse that starts and ends between two instants produces no event. `level_stat` shows the latched level.
- R9: The sampling period is 16 ticks when `period_long`=0 and 64 ticks when `period_long`=1.
- R10: `bias_out` is high during the last 2 ticks of each period and drops at the sampling instant. It is 0 whenever no pin has `samp_en` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_raw | input | 2 | Asynchronous wake-up pin levels |
| edge_cfg | input | 4 | Per-pin edge selection, 2 bits per pin |
| samp_en | input | 2 | Per-pin sampled-mode enable |
| period_long | input | 1 | Period select: 0 gives 16 ticks, 1 gives 64 ticks |
| chip_mode | input | 2 | 00 Sleep, 01 Standby, 1x Normal |
| ms_tick | input | 1 | One-cycle millisecond tick |
| bias_out | output | 1 | Bias strobe for external wake switches |
| wake_evt | output | 2 | Per-pin wake event pulse (Standby/Normal) |
| level_stat | output | 2 | Observed pin levels, gated by configuration |
| wake_req | output | 1 | Sleep-to-Standby wake request pulse |

## Verification
The one-cycle pulse properties assume that each synchronized pin holds its level for at least two clock cycles. They also assume that `ms_tick` is never high on two cycles in a row. The stable-level property assumes that `edge_cfg` changes only while no edge is pending. The stimulus keeps to all of these: it holds every pin change for several cycles, issues ticks as isolated single-cycle pulses, and changes configuration, mode and sample enables only while the pins are settled. This keeps any configuration change from creating or masking an edge.

// File: rtl/wake_pin_detect.sv
module wake_pin_detect #(
  parameter int NPIN        = 2,
  parameter int SHORT_TICKS = 16,
  parameter int LONG_TICKS  = 64,
  parameter int LEAD_TICKS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_raw,
  input  logic [2*NPIN-1:0] edge_cfg,
  input  logic [NPIN-1:0]   samp_en,
  input  logic              period_long,
  input  logic [1:0]        chip_mode,
  input  logic              ms_tick,
  output logic              bias_out,
  output logic [NPIN-1:0]   wake_evt,
  output logic [NPIN-1:0]   level_stat,
  output logic              wake_req
);
  localparam int CW = $clog2(LONG_TICKS + 1);

  logic [NPIN-1:0] sync1, sync2, held, prev;
  logic [CW-1:0]   cnt;
  logic [NPIN-1:0] cur, rise, fall, hit, upd;

  wire [CW-1:0] plen     = period_long ? CW'(LONG_TICKS) : CW'(SHORT_TICKS);
  wire          any_samp = |samp_en;
  wire          at_end   = (cnt >= plen - CW'(1));
  wire          samp_now = any_samp & ms_tick & at_end;
  wire          asleep   = (chip_mode == 2'b00);

  assign cur  = (samp_en & held) | (~samp_en & sync2);
  assign rise = cur & ~prev;
  assign fall = ~cur & prev;
  assign upd  = ~samp_en | {NPIN{samp_now}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      held  <= '0;
      prev  <= '0;
      cnt   <= '0;
    end else begin
      sync1 <= pin_raw;
      sync2 <= sync1;
      held  <= (upd & sync2) | (~upd & held);
      prev  <= cur;
      if (!any_samp)
        cnt <= '0;
      else if (ms_tick)
        cnt <= at_end ? '0 : cnt + CW'(1);
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    assign hit[i] = (edge_cfg[2*i+1] & rise[i]) | (edge_cfg[2*i] & fall[i]);
  end

  assign bias_out   = any_samp & (cnt >= plen - CW'(LEAD_TICKS));
  assign wake_evt   = asleep ? '0 : hit;
  assign wake_req   = asleep & (|hit);
  assign level_stat = (|edge_cfg) ? cur : '0;
endmodule

// File: rtl/wake_pin_detect_chk.sv
module wake_pin_detect_chk #(
  parameter int NPIN = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2*NPIN-1:0] edge_cfg,
  input logic [NPIN-1:0]   samp_en,
  input logic [1:0]        chip_mode,
  input logic              ms_tick,
  input logic              bias_out,
  input logic [NPIN-1:0]   wake_evt,
  input logic [NPIN-1:0]   level_stat,
  input logic              wake_req
);
  a_r5_no_event_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    chip_mode == 2'b00 |-> wake_evt == '0);

  a_r5_request_only_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> chip_mode == 2'b00);

  a_r6_level_gated: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cfg == '0 |-> level_stat == '0);

  a_r10_bias_idle: assert property (@(posedge clk) disable iff (!rst_n)
    samp_en == '0 |-> !bias_out);

  a_r7_request_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);

  for (genvar i = 0; i < NPIN; i++) begin : g_chk
    a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      edge_cfg[2*i +: 2] == 2'b00 |-> !wake_evt[i]);

    a_r7_event_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wake_evt[i] |=> !wake_evt[i]);

    a_r8_sampled_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
      samp_en[i] && $past(samp_en[i]) && !$past(ms_tick) && $stable(edge_cfg)
      |-> $stable(level_stat[i]));
  end
endmodule

bind wake_pin_detect wake_pin_detect_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_cfg(edge_cfg), .samp_en(samp_en),
  .chip_mode(chip_mode), .ms_tick(ms_tick), .bias_out(bias_out),
  .wake_evt(wake_evt), .level_stat(level_stat), .wake_req(wake_req));

// File: tb/wake_pin_detect_test.sv
module wake_pin_detect_test;
  logic       clk = 0, rst_n = 0;
  logic [1:0] pin_raw = 0, samp_en = 0, chip_mode = 2'b01;
  logic [3:0] edge_cfg = 0;
  logic       period_long = 0, ms_tick = 0;
  logic       bias_out, wake_req;
  logic [1:0] wake_evt, level_stat;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wake_pin_detect uut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    ms_tick = 1; @(negedge clk); ms_tick = 0;
  endtask

  // Drive one pin to a level and check the event at the synchronizer latency.
  task automatic edge_test(int p, bit lvl, string tag);
    bit counted;
    int cfg, ev_exp, rq_exp;
    cfg = edge_cfg[2*p +: 2];
    counted = lvl ? cfg[1] : cfg[0];
    ev_exp = (counted && chip_mode != 2'b00) ? (1 << p) : 0;
    rq_exp = (counted && chip_mode == 2'b00) ? 1 : 0;
    pin_raw[p] = lvl;
    cyc(1);
    chk({tag, " early"}, wake_evt, 0);
    cyc(1);
    chk(tag, wake_evt, ev_exp);
    chk({tag, " req"}, wake_req, rq_exp);
    chk({tag, " level"}, level_stat[p], (edge_cfg != 0) ? lvl : 0);
    cyc(1);
    chk({tag, " pulse end"}, {wake_req, wake_evt}, 0);
  endtask

  initial begin
    cyc(3);
    chk("R1 reset evt", wake_evt, 0);
    chk("R1 reset req", wake_req, 0);
    chk("R1 reset bias", bias_out, 0);
    rst_n = 1;
    cyc(1);
    chk("R1 after reset level", level_stat, 0);
    chk("R1 after reset evt", wake_evt, 0);

    // R2 R3 R4 R5 R6 R7: sweep pin x config x mode x edge direction
    for (int p = 0; p < 2; p++)
      for (int cfg = 0; cfg < 4; cfg++)
        for (int m = 0; m < 3; m++) begin
          chip_mode = (m == 0) ? 2'b00 : (m == 1) ? 2'b01 : 2'b10;
          edge_cfg = '0;
          edge_cfg[2*p +: 2] = cfg[1:0];
          edge_cfg[2*(1-p) +: 2] = 2'b11;
          cyc(1);
          edge_test(p, 1'b1, "R2 R4 R5 R7 rise");
          chk("R3 other pin quiet", wake_evt[1-p], 0);
          edge_test(p, 1'b0, "R2 R4 R5 R7 fall");
          chk("R10 bias idle", bias_out, 0);
        end

    // R6: all disabled gates level status
    edge_cfg = 0; pin_raw = 2'b11;
    cyc(3);
    chk("R6 gated level", level_stat, 0);
    chk("R2 disabled no evt", wake_evt, 0);
    edge_cfg = 4'b1000;
    cyc(1);
    chk("R6 level shown", level_stat, 3);
    tick(); tick();
    chk("R10 no bias without sampling", bias_out, 0);
    pin_raw = 0; edge_cfg = 0;
    cyc(3);

    // R8 R9 R10: sampled mode, short period
    chip_mode = 2'b01; edge_cfg = 4'b0011; samp_en = 2'b01; period_long = 0;
    cyc(1);
    pin_raw[0] = 1;
    cyc(4);
    chk("R8 no evt before sample", wake_evt, 0);
    chk("R8 level holds old sample", level_stat[0], 0);
    for (int k = 1; k <= 16; k++) begin
      tick();
      chk("R10 bias window", bias_out, (k >= 14 && k < 16) ? 1 : 0);
      chk("R8 R9 sample event", wake_evt, (k == 16) ? 1 : 0);
    end
    chk("R8 latched level", level_stat[0], 1);
    cyc(1);
    chk("R8 pulse end", wake_evt, 0);

    // R8: short pulse between samples is ignored
    for (int k = 1; k <= 16; k++) begin
      if (k == 3) pin_raw[0] = 0;
      if (k == 7) pin_raw[0] = 1;
      tick();
      chk("R8 glitch ignored", wake_evt, 0);
      chk("R8 glitch level", level_stat[0], 1);
    end

    // R9: long period
    period_long = 1;
    pin_raw[0] = 0;
    cyc(3);
    for (int k = 1; k <= 64; k++) begin
      tick();
      chk("R10 long bias window", bias_out, (k >= 62 && k < 64) ? 1 : 0);
      chk("R9 long sample event", wake_evt, (k == 64) ? 1 : 0);
    end
    chk("R8 long latched level", level_stat[0], 0);

    // R5 in sampled mode: Sleep gives a request
    chip_mode = 2'b00;
    pin_raw[0] = 1;
    cyc(3);
    for (int k = 1; k <= 64; k++) begin
      tick();
      chk("R5 sampled request", wake_req, (k == 64) ? 1 : 0);
      chk("R5 sampled no evt", wake_evt, 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule